// File: doc/BRIEF.md
# Dithered LED modulator

This block drives a single LED with a brightness set by a level number. It does not emit one solid pulse per frame. It divides each frame into sixteen equal slots and looks up a 16-bit on/off pattern for the requested level. The lit slots in each pattern are spread as evenly as possible through the frame. A one-hot stepper walks through the slots, one slot per tick, and the LED follows the pattern bit that the stepper selects.

The tick can come from outside as an enable input, for example a 1.6 kHz strobe that gives a 100 Hz frame. Or an internal prescaler can derive it from the system clock, and in that case the same input acts as a run enable. The requested level is signed and may be out of range; the block clamps it. A new level takes effect only at a frame boundary, so a frame never mixes two patterns.

Top module: `dither_led`

## Requirements
- R1: After a synchronous reset the LED is off, the stepper stands at slot 0 and the active level is 0. The first frame after reset is therefore dark whatever level is requested.
- R2: Each tick advances the stepper by exactly one slot, in the order slot 0, 1, ..., 15. After slot 15 the next tick returns it to slot 0, so one frame is 16 ticks long.
- R3: On the tick that serves slot k, the LED is driven to bit k of the pattern for the active level, with bit 0 as the least significant bit. The patterns for levels 0 to 16 are: 0000, 0001, 0101, 0841, 1111, 2491, 4949, 54A9, 5555, AB55, B5B5, DB6D, DDDD, F7BD, FDFD, FFFD, FFFF (hexadecimal).
- R4: The level input is a two's-complement number. A negative request is clamped to level 0.
- R5: A request of 16 or more is clamped to level 16.
- R6: The level input is sampled only on the tick that serves slot 15, and that value is used for the whole of the following frame. Changes made at any other point in a frame have no effect on that frame.
- R7: The LED output is registered. It changes only on a clock edge where a tick is present. Between ticks it holds its value.
- R8: In prescaler mode (USE_EXT_TICK = 0), while the enable input is held high, a tick occurs on every PRESCALE-th clock edge after reset, starting with edge number PRESCALE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Slot tick (external mode) or prescaler run enable (prescaler mode) |
| level | input | LVL_W | Requested brightness level, signed |
| led | output | 1 | Registered LED drive bit |

## Verification
The main instance runs whole frames at levels 16, 1, 5, 8, 13 and 15. Full-on and single-slot patterns show that the slot order and the wrap are right. The irregular mid-range patterns catch a bit-order or off-by-one slot error, because a shifted or reversed pattern differs from the true one. The bench requests −3 and 27 to check both clamp directions. It changes the level in the middle of a frame to show that the level is taken only at the boundary. It leaves idle cycles between ticks to show that the output holds. A second instance in prescaler mode checks that the first lit slot appears on exactly the edge the tick count predicts.

// File: rtl/dither_led_pkg.sv
package dither_led_pkg;
  localparam int SLOTS   = 16;
  localparam int MAX_LVL = SLOTS;
  localparam int AW      = $clog2(MAX_LVL + 1);

  typedef logic [SLOTS-1:0] slot_vec_t;
  typedef logic [AW-1:0]    lvl_t;

  // Spread-out on/off pattern per level: bit k lights slot k.
  function automatic slot_vec_t lvl_pattern(input lvl_t lv);
    case (lv)
      5'd0:    lvl_pattern = 16'h0000;
      5'd1:    lvl_pattern = 16'h0001;
      5'd2:    lvl_pattern = 16'h0101;
      5'd3:    lvl_pattern = 16'h0841;
      5'd4:    lvl_pattern = 16'h1111;
      5'd5:    lvl_pattern = 16'h2491;
      5'd6:    lvl_pattern = 16'h4949;
      5'd7:    lvl_pattern = 16'h54A9;
      5'd8:    lvl_pattern = 16'h5555;
      5'd9:    lvl_pattern = 16'hAB55;
      5'd10:   lvl_pattern = 16'hB5B5;
      5'd11:   lvl_pattern = 16'hDB6D;
      5'd12:   lvl_pattern = 16'hDDDD;
      5'd13:   lvl_pattern = 16'hF7BD;
      5'd14:   lvl_pattern = 16'hFDFD;
      5'd15:   lvl_pattern = 16'hFFFD;
      default: lvl_pattern = 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/dither_led_prescale.sv
module dither_led_prescale #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else if (run)  cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (PRESCALE > 1) begin : g_spacing
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R8
    end
  endgenerate
endmodule

// File: rtl/dither_led_stepper.sv
module dither_led_stepper
  import dither_led_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  output slot_vec_t step,
  output logic      frame_end
);
  slot_vec_t step_q;

  always_ff @(posedge clk) begin
    if (rst)       step_q <= slot_vec_t'(1);
    else if (tick) step_q <= {step_q[SLOTS-2:0], step_q[SLOTS-1]};
  end

  assign step      = step_q;
  assign frame_end = tick && step_q[SLOTS-1];

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(step_q) == 1); // R2
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> step_q[0]); // R2
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(step_q)); // R7
endmodule

// File: rtl/dither_led_level.sv
module dither_led_level
  import dither_led_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic signed [LVL_W-1:0] req,
  output lvl_t                    active
);
  localparam logic signed [LVL_W-1:0] TOP_S = LVL_W'(MAX_LVL);

  lvl_t act_q;
  lvl_t clamped;

  always_comb begin
    if (req < 0)          clamped = '0;
    else if (req > TOP_S) clamped = lvl_t'(MAX_LVL);
    else                  clamped = req[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       act_q <= '0;
    else if (load) act_q <= clamped;
  end

  assign active = act_q;

  AST_LVL_BOUND: assert property (@(posedge clk) disable iff (rst)
    act_q <= lvl_t'(MAX_LVL)); // R5
  AST_LVL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act_q)); // R6
  AST_LVL_NEG: assert property (@(posedge clk) disable iff (rst)
    load && (req < 0) |=> act_q == '0); // R4
endmodule

// File: rtl/dither_led.sv
module dither_led
  import dither_led_pkg::*;
#(
  parameter bit USE_EXT_TICK = 1'b1,
  parameter int PRESCALE     = 4,
  parameter int LVL_W        = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_en,
  input  logic signed [LVL_W-1:0] level,
  output logic                    led
);
  logic      tick;
  logic      frame_end;
  slot_vec_t step;
  lvl_t      act_lvl;
  slot_vec_t pat;
  logic      led_q;

  generate
    if (USE_EXT_TICK) begin : g_ext
      assign tick = tick_en;
    end else begin : g_pre
      dither_led_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst(rst), .run(tick_en), .tick(tick));
    end
  endgenerate

  dither_led_stepper u_step (
    .clk(clk), .rst(rst), .tick(tick), .step(step), .frame_end(frame_end));

  dither_led_level #(.LVL_W(LVL_W)) u_lvl (
    .clk(clk), .rst(rst), .load(frame_end), .req(level), .active(act_lvl));

  assign pat = lvl_pattern(act_lvl);

  always_ff @(posedge clk) begin
    if (rst)       led_q <= 1'b0;
    else if (tick) led_q <= |(pat & step);
  end

  assign led = led_q;

  AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(led_q)); // R7
  AST_LED_DARK: assert property (@(posedge clk) disable iff (rst)
    tick && (act_lvl == '0) |=> !led_q); // R3
  AST_LED_FULL: assert property (@(posedge clk) disable iff (rst)
    tick && (act_lvl == lvl_t'(MAX_LVL)) |=> led_q); // R3
endmodule

// File: tb/dither_led_tb.sv
module dither_led_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic signed [5:0] level = '0;
  logic led;
  logic led_pre;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { logic v; string tag; } exp_t;
  exp_t q[$];

  // model state
  int m_idx = 0;
  int m_act = 0;
  logic m_led = 1'b0;

  always #5 clk = ~clk;

  dither_led u_dut (.clk(clk), .rst(rst), .tick_en(tick_en), .level(level), .led(led));

  dither_led #(.USE_EXT_TICK(1'b0), .PRESCALE(3)) u_dut_pre (
    .clk(clk), .rst(rst), .tick_en(1'b1), .level(6'sd16), .led(led_pre));

  function automatic logic [15:0] ref_pat(input int lv);
    case (lv)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0101;
      3: return 16'h0841;  4: return 16'h1111;  5: return 16'h2491;
      6: return 16'h4949;  7: return 16'h54A9;  8: return 16'h5555;
      9: return 16'hAB55; 10: return 16'hB5B5; 11: return 16'hDB6D;
      12: return 16'hDDDD; 13: return 16'hF7BD; 14: return 16'hFDFD;
      15: return 16'hFFFD; default: return 16'hFFFF;
    endcase
  endfunction

  function automatic int clamp(input logic signed [5:0] l);
    if (l < 0) return 0;
    if (l > 16) return 16;
    return int'(l);
  endfunction

  task automatic check(input logic act, input logic expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: led actual %b expected %b", tag, act, expv);
    end
  endtask

  // driver: one clock cycle, with or without a tick
  task automatic cyc(input bit t, input string tag);
    exp_t e;
    @(negedge clk) tick_en = t;
    @(posedge clk);
    #1;
    if (t) begin
      m_led = ref_pat(m_act)[m_idx];
      if (m_idx == 15) begin
        m_idx = 0;
        m_act = clamp(level);
      end else m_idx++;
    end
    e.v = m_led;
    e.tag = t ? tag : "R7 hold between ticks";
    q.push_back(e);
  endtask

  task automatic frame(input int gap, input string tag);
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, tag);
      for (int g = 0; g < gap; g++) cyc(1'b0, tag);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(led, e.v, e.tag);
    end
  end

  // R8: prescaler instance, level 16, tick every 3rd edge
  initial begin
    wait (rst == 1'b0);
    repeat (50) @(posedge clk);
    #1 check(led_pre, 1'b0, "R8 prescaler first lit slot not before edge 51");
    @(posedge clk);
    #1 check(led_pre, 1'b1, "R8 prescaler first lit slot at edge 51");
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(led, 1'b0, "R1 led off in reset");
    @(negedge clk) rst = 1'b0;
    level = 6'sd16;
    frame(0, "R1 first frame dark");
    frame(1, "R3 level 16 full on");
    level = 6'sd1;
    frame(0, "R3 level 16 again, level 1 pending");
    frame(2, "R3 level 1 single slot");
    level = 6'sd5;
    frame(0, "R3 level 1 wrap");
    level = 6'sd8;
    frame(1, "R3 level 5 pattern");
    level = 6'sd13;
    frame(0, "R3 level 8 pattern");
    // mid-frame change must not affect the current frame
    for (int i = 0; i < 7; i++) cyc(1'b1, "R6 level 13 before mid-frame change");
    level = 6'sd2;
    for (int i = 0; i < 9; i++) cyc(1'b1, "R6 level 13 kept after mid-frame change");
    level = 6'sd15;
    frame(0, "R6 new level 15 pending");
    level = -6'sd3;
    frame(0, "R3 level 15 pattern");
    level = 6'sd27;
    frame(1, "R4 negative clamped to 0");
    level = 6'sd0;
    frame(0, "R5 over-range clamped to 16");
    for (int g = 0; g < 5; g++) cyc(1'b0, "R7");
    frame(0, "R3 level 0 dark");
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule